// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block stores one line of a video or scanner stream, 5120 words of 8 bits, so that the line can be played back later. It has a write side and a read side. Each side has its own clock, its own active-low enable and its own active-low synchronous address reset. Each side also has its own address counter, and both counters walk through the storage in ascending order.

There is no full/empty comparison between the two counters. The delay between the stored stream and the replayed stream is set only by when each side is rewound to address 0. A typical use rewinds both sides at the start of a line. The read side then trails the write side by the wanted number of words.

The read word is registered. A separate output-enable flag stands in for a tri-stated output bus: it is high only for a read cycle and low after any cycle in which reads are disabled.

Top module: `lineDelayMem`

## Requirements
- R1: At a rising write-clock edge with wEnN low, wData is stored at the current write address, and the write address advances by one on that same edge.
- R2: At a rising write-clock edge with wEnN high, no word is stored and the write address holds.
- R3: At a rising write-clock edge with wResN low, the write address goes to 0. If wEnN is also low, wData is stored at address 0 and the write address becomes 1.
- R4: At a rising read-clock edge with rEnN low, the word at the current read address appears on q after that edge, qOe goes to 1, and the read address advances by one.
- R5: At a rising read-clock edge with rEnN high, qOe goes to 0 and the read address holds, so the next enabled read returns the following word in order.
- R6: At a rising read-clock edge with rResN low, the read address goes to 0. If rEnN is also low, the word at address 0 is output and the read address becomes 1.
- R7: Both addresses stay in the range 0 to DEPTH-1 and wrap from DEPTH-1 to 0 when they advance, including when DEPTH is not a power of two.
- R8: The two clocks are independent. A read stream running on its own clock, kept behind the write stream, returns the written words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write-side clock, rising edge active |
| wEnN | input | 1 | Write enable, active low |
| wResN | input | 1 | Write address rewind to 0, active low, synchronous to wClk |
| wData | input | WIDTH | Word to store |
| rClk | input | 1 | Read-side clock, rising edge active |
| rEnN | input | 1 | Read enable, active low |
| rResN | input | 1 | Read address rewind to 0, active low, synchronous to rClk |
| q | output | WIDTH | Registered read word |
| qOe | output | 1 | High when q carries a word read on the last read-clock edge; low stands for a floating bus |

## Verification
A write counter that skips, sticks or wraps at the wrong count does not show up at once. It surfaces on the first read that reaches the affected address, which can be up to a full line later. This is why the sweeps replay every address and cross the wrap point with a depth that is not a power of two. A wrong read counter or output flag shows one read-clock edge after the faulty access, as a word out of order or a wrong qOe level.

// File: rtl/lineMemPkg.sv
`timescale 1ns/1ps
package lineMemPkg;
  // Per-port strobes handed from control to datapath, decoded from active-low pins
  typedef struct packed {
    logic access;   // enable asserted at this edge
    logic rewind;   // address reset asserted at this edge
  } portCmd_t;
endpackage

// File: rtl/lineMemCtrl.sv
`timescale 1ns/1ps
module lineMemCtrl
  import lineMemPkg::*;
#(
  parameter int DEPTH = 5120,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          enN,
  input  logic          resN,
  output portCmd_t      cmd,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] effAddr;

  assign cmd.access = ~enN;
  assign cmd.rewind = ~resN;

  // address used on this edge: rewind wins over the stored count
  assign effAddr = cmd.rewind ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (cmd.access) begin
      ptr <= (effAddr == LAST) ? '0 : effAddr + 1'b1;
    end else begin
      ptr <= effAddr;
    end
  end
endmodule

// File: rtl/lineMemData.sv
`timescale 1ns/1ps
module lineMemData
  import lineMemPkg::*;
#(
  parameter int DEPTH = 5120,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wClk,
  input  portCmd_t         wrCmd,
  input  logic [AW-1:0]    wrPtr,
  input  logic [WIDTH-1:0] wData,
  input  logic             rClk,
  input  portCmd_t         rdCmd,
  input  logic [AW-1:0]    rdPtr,
  output logic [WIDTH-1:0] q,
  output logic             qOe
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrAddr;
  logic [AW-1:0]    rdAddr;

  assign wrAddr = wrCmd.rewind ? '0 : wrPtr;
  assign rdAddr = rdCmd.rewind ? '0 : rdPtr;

  always_ff @(posedge wClk) begin
    if (wrCmd.access) begin
      store[wrAddr] <= wData;
    end
  end

  always_ff @(posedge rClk) begin
    qOe <= rdCmd.access;
    if (rdCmd.access) begin
      q <= store[rdAddr];
    end
  end
endmodule

// File: rtl/lineDelayMem.sv
`timescale 1ns/1ps
module lineDelayMem
  import lineMemPkg::*;
#(
  parameter int DEPTH = 5120,
  parameter int WIDTH = 8
) (
  input  logic             wClk,
  input  logic             wEnN,
  input  logic             wResN,
  input  logic [WIDTH-1:0] wData,
  input  logic             rClk,
  input  logic             rEnN,
  input  logic             rResN,
  output logic [WIDTH-1:0] q,
  output logic             qOe
);
  localparam int AW = $clog2(DEPTH);

  portCmd_t      wrCmd;
  portCmd_t      rdCmd;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  lineMemCtrl #(.DEPTH(DEPTH)) wrSide (
    .clk(wClk), .enN(wEnN), .resN(wResN), .cmd(wrCmd), .ptr(wrPtr)
  );

  lineMemCtrl #(.DEPTH(DEPTH)) rdSide (
    .clk(rClk), .enN(rEnN), .resN(rResN), .cmd(rdCmd), .ptr(rdPtr)
  );

  lineMemData #(.DEPTH(DEPTH), .WIDTH(WIDTH)) datapath (
    .wClk(wClk), .wrCmd(wrCmd), .wrPtr(wrPtr), .wData(wData),
    .rClk(rClk), .rdCmd(rdCmd), .rdPtr(rdPtr), .q(q), .qOe(qOe)
  );
endmodule

// File: rtl/lineDelayMemChk.sv
`timescale 1ns/1ps
module lineDelayMemChk #(
  parameter int DEPTH = 5120,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          wClk,
  input logic          wEnN,
  input logic          wResN,
  input logic          rClk,
  input logic          rEnN,
  input logic          rResN,
  input logic [AW-1:0] wrPtr,
  input logic [AW-1:0] rdPtr,
  input logic          qOe
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] stepOf(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic wSeen = 1'b0;
  logic rSeen = 1'b0;

  always_ff @(posedge wClk) if (!wResN) wSeen <= 1'b1;
  always_ff @(posedge rClk) if (!rResN) rSeen <= 1'b1;

  AST_WR_STEP: assert property (@(posedge wClk) disable iff (!wSeen)
    (wResN && !wEnN) |=> wrPtr == stepOf($past(wrPtr)));          // R1
  AST_WR_HOLD: assert property (@(posedge wClk) disable iff (!wSeen)
    (wResN && wEnN) |=> $stable(wrPtr));                          // R2
  AST_WR_REWIND: assert property (@(posedge wClk) disable iff (!wSeen)
    !wResN |=> wrPtr == ($past(wEnN) ? AW'(0) : AW'(1)));         // R3
  AST_RD_STEP: assert property (@(posedge rClk) disable iff (!rSeen)
    (rResN && !rEnN) |=> rdPtr == stepOf($past(rdPtr)));          // R4
  AST_RD_HOLD: assert property (@(posedge rClk) disable iff (!rSeen)
    (rResN && rEnN) |=> $stable(rdPtr));                          // R5
  AST_OE_TRACK: assert property (@(posedge rClk) disable iff (!rSeen)
    1'b1 |=> qOe == !$past(rEnN));                                // R5
  AST_RD_REWIND: assert property (@(posedge rClk) disable iff (!rSeen)
    !rResN |=> rdPtr == ($past(rEnN) ? AW'(0) : AW'(1)));         // R6
  AST_WR_RANGE: assert property (@(posedge wClk) disable iff (!wSeen)
    wrPtr <= LAST);                                               // R7
  AST_RD_RANGE: assert property (@(posedge rClk) disable iff (!rSeen)
    rdPtr <= LAST);                                               // R7
endmodule

bind lineDelayMem lineDelayMemChk #(.DEPTH(DEPTH)) chk (.*);

// File: tb/lineDelayMem_test.sv
`timescale 1ns/1ps
module lineDelayMem_test;
  localparam int D = 20;
  localparam int W = 8;

  logic wClk = 1'b0;
  logic rClk = 1'b0;
  logic wEnN = 1'b1, wResN = 1'b1, rEnN = 1'b1, rResN = 1'b1;
  logic [W-1:0] wData = '0;
  logic [W-1:0] q;
  logic qOe;

  always #4 wClk = ~wClk;     // 125 MHz write clock
  always #5.5 rClk = ~rClk;   // independent read clock

  lineDelayMem #(.DEPTH(D), .WIDTH(W)) uut (
    .wClk(wClk), .wEnN(wEnN), .wResN(wResN), .wData(wData),
    .rClk(rClk), .rEnN(rEnN), .rResN(rResN), .q(q), .qOe(qOe)
  );

  int total = 0;
  int bad = 0;
  logic [W-1:0] model [D];
  int wPtr = 0;
  int rPtr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit rst, input logic [W-1:0] d);
    int a;
    @(negedge wClk);
    wEnN = !en; wResN = !rst; wData = d;
    @(posedge wClk);
    a = rst ? 0 : wPtr;
    if (en) begin
      model[a] = d;
      wPtr = (a + 1) % D;
    end else begin
      wPtr = a;
    end
    #1;
    wEnN = 1'b1; wResN = 1'b1;
  endtask

  task automatic rd(input bit en, input bit rst, input string tag);
    int a;
    @(negedge rClk);
    rEnN = !en; rResN = !rst;
    @(posedge rClk);
    #1;
    a = rst ? 0 : rPtr;
    if (en) begin
      check(qOe === 1'b1, tag, int'(qOe), 1);
      check(q === model[a], tag, int'(q), int'(model[a]));
      rPtr = (a + 1) % D;
    end else begin
      check(qOe === 1'b0, tag, int'(qOe), 0);
      rPtr = a;
    end
    rEnN = 1'b1; rResN = 1'b1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    // reset state: both sides rewound, reads off
    wr(1'b0, 1'b1, '0);
    rd(1'b0, 1'b1, "R5 reset qOe");

    // R1 / R4: fill every address, replay every address
    for (int i = 0; i < D; i++) wr(1'b1, 1'b0, W'(i * 7 + 3));
    for (int i = 0; i < D; i++) rd(1'b1, 1'b0, "R4 full sweep");

    // R2: write enable gaps leave old words and hold the address
    for (int i = 0; i < D; i++) wr((i % 3) != 0, 1'b0, W'(8'hA0 + i));
    for (int i = 0; i < D; i++) rd(1'b1, 1'b0, "R2 gap sweep");

    // R7: run both counters past the end of a non-power-of-two depth
    for (int i = 0; i < D + 3; i++) wr(1'b1, 1'b0, W'(i * 11 + 1));
    for (int i = 0; i < D + 5; i++) rd(1'b1, 1'b0, "R7 wrap sweep");

    // R5: disabled read cycles drop qOe and hold the order
    rd(1'b1, 1'b0, "R5 before gap");
    rd(1'b0, 1'b0, "R5 gap");
    rd(1'b0, 1'b0, "R5 gap");
    rd(1'b1, 1'b0, "R5 after gap");

    // R3: rewind with and without enable
    wr(1'b1, 1'b1, 8'h5A);
    wr(1'b1, 1'b0, 8'hC3);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b1, 1'b0, 8'h77);
    // R6: read rewind with enable, then without
    rd(1'b1, 1'b1, "R6 rewind+read addr0");
    rd(1'b1, 1'b0, "R3 R6 addr1 word");
    rd(1'b0, 1'b1, "R6 rewind only");
    rd(1'b1, 1'b0, "R6 addr0 after rewind");

    // R8: concurrent streams on separate clocks, read kept behind
    wr(1'b1, 1'b1, 8'h10);
    for (int i = 1; i < 4; i++) wr(1'b1, 1'b0, W'(8'h10 + i));
    fork
      begin
        for (int i = 4; i < 18; i++) wr(1'b1, 1'b0, W'(8'h10 + i));
      end
      begin
        rd(1'b1, 1'b1, "R8 concurrent");
        for (int i = 1; i < 16; i++) rd(1'b1, 1'b0, "R8 concurrent");
      end
    join

    summary();
    $finish;
  end
endmodule